// File: doc/BRIEF.md
# Cartridge Program/Character Bank Mapper

This block sits between an 8-bit console's CPU and video buses and the memories on a game cartridge. It holds one write-only control byte that is reached by any CPU write in the upper half of the address space ($8000-$FFFF). From that byte it picks which 16 KiB slice of program ROM appears in the lower program window ($8000-$BFFF). The upper window ($C000-$FFFF) is wired to the final ROM bank. The same byte carries an on/off switch for an 8 KiB character RAM on the video bus.

On the cartridge, the ROM keeps driving the data bus while the CPU writes. The stored value is therefore the CPU byte ANDed with the ROM byte at the write address, and the block models that. While the character RAM is switched off, video-side reads see 0x00 and video-side writes never reach the storage. Nametable mirroring comes from a board strap and passes straight through. The block has no interrupt output. The ROM and RAM arrays themselves are outside the block.

Top module: `cart_bankmap`

## Requirements
- R1: Only a CPU write (cpu_wr high at a rising clock edge) with cpu_addr bit 15 set updates the control byte; writes with cpu_addr below $8000 leave every output mapping unchanged.
- R2: The stored control byte is cpu_wdata bitwise ANDed with rom_rdata, sampled at the write edge. rom_rdata is the ROM byte at the address that rom_addr presents during that cycle.
- R3: For cpu_addr in $8000-$BFFF, rom_addr is {bank, cpu_addr[13:0]}, where bank is taken from control bits 6:4. Control bits 7 and 3:1 have no effect.
- R4: For cpu_addr in $C000-$FFFF, the bank field of rom_addr (bits above bit 13) is always PRG_BANKS-1, whatever the control byte holds.
- R5: When control bit 0 is 1, PPU accesses to $0000-$1FFF reach the RAM. chr_addr is ppu_addr[12:0] and chr_wdata is ppu_wdata. A PPU write raises chr_we and chr_ce. A PPU read raises chr_ce and returns chr_rdata on ppu_rdata. Accesses with ppu_addr bit 13 set never reach the RAM and read as 0x00.
- R6: When control bit 0 is 0, chr_we and chr_ce stay low and ppu_rdata is 0x00, so PPU writes are dropped and the stored RAM contents are kept.
- R7: While rst_n is low, and after it is released, the bank field is 0 and the character RAM is disabled until the next qualifying write.
- R8: mirror_sel always equals mirror_strap, and register writes never change it.
- R9: The switchable bank is the control field modulo PRG_BANKS, so a 5-bank ROM maps field values 5, 6 and 7 to banks 0, 1 and 2.
- R10: A new mapping takes effect in the cycle after the write edge. During the write cycle itself, rom_addr still shows the old mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| rom_rdata | input | 8 | ROM byte at rom_addr |
| rom_addr | output | ROM_AW (17) | Program ROM address {bank, A13:A0} |
| ppu_addr | input | 14 | PPU address |
| ppu_wdata | input | 8 | PPU write data |
| ppu_rd | input | 1 | PPU read strobe |
| ppu_wr | input | 1 | PPU write strobe |
| chr_rdata | input | 8 | Character RAM read data |
| chr_addr | output | 13 | Character RAM address |
| chr_wdata | output | 8 | Character RAM write data |
| chr_ce | output | 1 | Character RAM chip enable |
| chr_we | output | 1 | Character RAM write enable |
| ppu_rdata | output | 8 | Data returned to the PPU |
| mirror_strap | input | 1 | Board mirroring configuration |
| mirror_sel | output | 1 | Nametable mirroring select |

## Verification
The ROM model returns a byte that depends on both the bank and the low address bits. Random writes therefore produce bus-conflict values in which bits get cleared, which shows whether the AND with the ROM byte is applied before latching. Directed writes to a location that holds 0xFF show that the selection field is decoded correctly and that the ignored bits really are ignored. A second instance built for 5 banks is driven with the same writes, so field values above 4 separate modulo reduction from plain truncation. PPU traffic is interleaved with enable and disable writes and with accesses that have address bit 13 set. This shows whether disabled writes leak into storage and whether data written while enabled survives a disabled period.

// File: rtl/cart_bankmap_pkg.sv
package cart_bankmap_pkg;
  localparam int unsigned WIN_AW     = 14;  // 16 KiB program window
  localparam int unsigned CHR_AW     = 13;  // 8 KiB character RAM
  localparam int unsigned SEL_W      = 3;   // bank field width in control byte
  localparam int unsigned SEL_LSB    = 4;   // bank field position
  localparam int unsigned CHR_EN_BIT = 0;   // character RAM switch position

  typedef struct packed {
    logic [SEL_W-1:0] bank;
    logic             chr_en;
  } ctrl_t;
endpackage

// File: rtl/cbm_rst_sync.sv
module cbm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/cbm_ctrl_reg.sv
module cbm_ctrl_reg
  import cart_bankmap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_hi,     // CPU address bit 15
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  input  logic [7:0] rom_rdata,
  output ctrl_t      ctrl_q
);
  logic [7:0] merged;
  logic       load_en;
  ctrl_t      ctrl_d;

  // next-state: bus conflict merge and field extraction
  always_comb begin
    merged        = cpu_wdata & rom_rdata;
    load_en       = cpu_wr & cpu_hi;
    ctrl_d.bank   = merged[SEL_LSB +: SEL_W];
    ctrl_d.chr_en = merged[CHR_EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (load_en) ctrl_q <= ctrl_d;
  end

  assert_ignore_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_hi) |=> $stable(ctrl_q));

  assert_conflict_and_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_hi) |=>
      (ctrl_q.bank == $past(cpu_wdata[6:4] & rom_rdata[6:4])) &&
      (ctrl_q.chr_en == $past(cpu_wdata[0] & rom_rdata[0])));
endmodule

// File: rtl/cbm_prg_xlate.sv
module cbm_prg_xlate
  import cart_bankmap_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 8,
  parameter int unsigned BANK_W    = 3,
  parameter int unsigned ROM_AW    = BANK_W + WIN_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  bank_sel,
  input  logic [14:0]       win_addr,   // CPU A14:A0
  output logic [ROM_AW-1:0] rom_addr
);
  localparam int unsigned LAST_BANK = PRG_BANKS - 1;

  logic [BANK_W-1:0] sw_bank;
  logic [BANK_W-1:0] use_bank;

  always_comb begin
    sw_bank  = BANK_W'(32'(bank_sel) % PRG_BANKS);
    use_bank = win_addr[14] ? BANK_W'(LAST_BANK) : sw_bank;
    rom_addr = {use_bank, win_addr[WIN_AW-1:0]};
  end

  assert_fixed_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_addr[14] |-> (32'(rom_addr[ROM_AW-1:WIN_AW]) == LAST_BANK));

  assert_bank_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rom_addr[ROM_AW-1:WIN_AW]) < PRG_BANKS);
endmodule

// File: rtl/cbm_vram_gate.sv
module cbm_vram_gate
  import cart_bankmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chr_en,
  input  logic [13:0]       ppu_addr,
  input  logic [7:0]        ppu_wdata,
  input  logic              ppu_rd,
  input  logic              ppu_wr,
  input  logic [7:0]        chr_rdata,
  output logic [CHR_AW-1:0] chr_addr,
  output logic [7:0]        chr_wdata,
  output logic              chr_ce,
  output logic              chr_we,
  output logic [7:0]        ppu_rdata
);
  logic pattern_hit;
  logic pass;

  always_comb begin
    pattern_hit = ~ppu_addr[13];
    pass        = chr_en & pattern_hit;
    chr_addr    = ppu_addr[CHR_AW-1:0];
    chr_wdata   = ppu_wdata;
    chr_ce      = pass & (ppu_rd | ppu_wr);
    chr_we      = pass & ppu_wr;
    ppu_rdata   = (pass & ppu_rd) ? chr_rdata : 8'h00;
  end

  assert_off_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !chr_en |-> (!chr_we && !chr_ce && (ppu_rdata == 8'h00)));

  assert_we_needs_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chr_we |-> (ppu_wr && chr_ce));
endmodule

// File: rtl/cart_bankmap.sv
module cart_bankmap
  import cart_bankmap_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 8,
  localparam int unsigned BANK_W   = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
  localparam int unsigned ROM_AW   = BANK_W + WIN_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic [7:0]        rom_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [13:0]       ppu_addr,
  input  logic [7:0]        ppu_wdata,
  input  logic              ppu_rd,
  input  logic              ppu_wr,
  input  logic [7:0]        chr_rdata,
  output logic [12:0]       chr_addr,
  output logic [7:0]        chr_wdata,
  output logic              chr_ce,
  output logic              chr_we,
  output logic [7:0]        ppu_rdata,
  input  logic              mirror_strap,
  output logic              mirror_sel
);
  logic  rst_core_n;
  ctrl_t ctrl_q;

  cbm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  cbm_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cpu_hi    (cpu_addr[15]),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .rom_rdata (rom_rdata),
    .ctrl_q    (ctrl_q)
  );

  cbm_prg_xlate #(
    .PRG_BANKS (PRG_BANKS),
    .BANK_W    (BANK_W),
    .ROM_AW    (ROM_AW)
  ) u_prg (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .bank_sel (ctrl_q.bank),
    .win_addr (cpu_addr[14:0]),
    .rom_addr (rom_addr)
  );

  cbm_vram_gate u_chr (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .chr_en    (ctrl_q.chr_en),
    .ppu_addr  (ppu_addr),
    .ppu_wdata (ppu_wdata),
    .ppu_rd    (ppu_rd),
    .ppu_wr    (ppu_wr),
    .chr_rdata (chr_rdata),
    .chr_addr  (chr_addr),
    .chr_wdata (chr_wdata),
    .chr_ce    (chr_ce),
    .chr_we    (chr_we),
    .ppu_rdata (ppu_rdata)
  );

  assign mirror_sel = mirror_strap;
endmodule

// File: tb/cart_bankmap_tb_top.sv
`timescale 1ns/1ps
module cart_bankmap_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_wr;
  logic [13:0] ppu_addr;
  logic [7:0]  ppu_wdata;
  logic        ppu_rd, ppu_wr;
  logic        mirror_strap;

  logic [16:0] rom_addr8, rom_addr5;
  logic [7:0]  rom_rdata8, rom_rdata5;
  logic [12:0] chr_addr8, chr_addr5;
  logic [7:0]  chr_wdata8, chr_wdata5;
  logic        chr_ce8, chr_ce5, chr_we8, chr_we5;
  logic [7:0]  chr_rd8;
  logic [7:0]  ppu_rdata8, ppu_rdata5;
  logic        mirror_sel8, mirror_sel5;

  logic [7:0] chr_mem [0:8191];
  logic [7:0] exp_mem [0:8191];

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  int m_bank8, m_bank5;
  bit m_en8, m_en5;

  function automatic logic [7:0] rom_fn(logic [16:0] a);
    return a[7:0] ^ {1'b0, a[16:14], 4'h0};
  endfunction

  function automatic logic [16:0] exp_rom(logic [15:0] a, int bank, int nb);
    int b;
    b = a[14] ? nb - 1 : bank % nb;
    return {b[2:0], a[13:0]};
  endfunction

  assign rom_rdata8 = rom_fn(rom_addr8);
  assign rom_rdata5 = rom_fn(rom_addr5);
  assign chr_rd8    = chr_mem[chr_addr8];

  always @(posedge clk) if (chr_we8) chr_mem[chr_addr8] <= chr_wdata8;

  cart_bankmap #(.PRG_BANKS(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .rom_rdata(rom_rdata8), .rom_addr(rom_addr8),
    .ppu_addr(ppu_addr), .ppu_wdata(ppu_wdata), .ppu_rd(ppu_rd), .ppu_wr(ppu_wr),
    .chr_rdata(chr_rd8), .chr_addr(chr_addr8), .chr_wdata(chr_wdata8),
    .chr_ce(chr_ce8), .chr_we(chr_we8), .ppu_rdata(ppu_rdata8),
    .mirror_strap(mirror_strap), .mirror_sel(mirror_sel8)
  );

  cart_bankmap #(.PRG_BANKS(5)) dut5_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .rom_rdata(rom_rdata5), .rom_addr(rom_addr5),
    .ppu_addr(ppu_addr), .ppu_wdata(ppu_wdata), .ppu_rd(ppu_rd), .ppu_wr(ppu_wr),
    .chr_rdata(8'h00), .chr_addr(chr_addr5), .chr_wdata(chr_wdata5),
    .chr_ce(chr_ce5), .chr_we(chr_we5), .ppu_rdata(ppu_rdata5),
    .mirror_strap(mirror_strap), .mirror_sel(mirror_sel5)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_strobes();
    cpu_wr = 1'b0; ppu_rd = 1'b0; ppu_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_strobes();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_bank8 = 0; m_bank5 = 0; m_en8 = 0; m_en5 = 0;
  endtask

  task automatic cpu_write(logic [15:0] a, logic [7:0] d, string req);
    logic [7:0] e8, e5;
    @(negedge clk);
    idle_strobes();
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    #1;
    e8 = d & rom_fn(exp_rom(a, m_bank8, 8));
    e5 = d & rom_fn(exp_rom(a, m_bank5, 5));
    if (a[15]) chk({req, "/R10 old map"}, 32'(rom_addr8), 32'(exp_rom(a, m_bank8, 8)));
    @(posedge clk);
    if (a[15]) begin
      m_bank8 = int'(e8[6:4]); m_en8 = e8[0];
      m_bank5 = int'(e5[6:4]); m_en5 = e5[0];
    end
  endtask

  task automatic check_rom(logic [15:0] a, string req);
    @(negedge clk);
    idle_strobes();
    cpu_addr = a;
    #1;
    chk({req, " rom8"}, 32'(rom_addr8), 32'(exp_rom(a, m_bank8, 8)));
    chk({req, " rom5"}, 32'(rom_addr5), 32'(exp_rom(a, m_bank5, 5)));
  endtask

  task automatic ppu_write(logic [13:0] a, logic [7:0] d, string req);
    bit ok;
    @(negedge clk);
    idle_strobes();
    ppu_addr = a; ppu_wdata = d; ppu_wr = 1'b1;
    #1;
    ok = m_en8 && !a[13];
    chk({req, " chr_we"}, 32'(chr_we8), 32'(ok));
    if (ok) chk({req, " chr_addr"}, 32'(chr_addr8), 32'(a[12:0]));
    @(posedge clk);
    if (ok) exp_mem[a[12:0]] = d;
  endtask

  task automatic ppu_read(logic [13:0] a, string req);
    logic [7:0] e;
    @(negedge clk);
    idle_strobes();
    ppu_addr = a; ppu_rd = 1'b1;
    #1;
    e = (m_en8 && !a[13]) ? exp_mem[a[12:0]] : 8'h00;
    chk({req, " ppu_rdata"}, 32'(ppu_rdata8), 32'(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8192; i++) begin chr_mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    rst_n = 1'b0; cpu_addr = 16'h0000; cpu_wdata = 8'h00; ppu_addr = 14'h0;
    ppu_wdata = 8'h00; mirror_strap = 1'b0; idle_strobes();
    void'($urandom(32'h5EED_0093));
    do_reset();

    // reset state
    check_rom(16'h8123, "R7");
    check_rom(16'hC000, "R4");
    ppu_read(14'h0000, "R7");

    // disabled RAM drops writes
    ppu_write(14'h0100, 8'h55, "R6");
    cpu_write(16'h80FF, 8'h01, "R5");      // ROM byte 0xFF: bank 0, enabled
    ppu_read(14'h0100, "R6");

    // enabled RAM, both ends, and bit 13 region
    ppu_write(14'h0000, 8'h11, "R5");
    ppu_write(14'h1FFF, 8'h22, "R5");
    ppu_read(14'h0000, "R5");
    ppu_read(14'h1FFF, "R5");
    ppu_write(14'h2005, 8'h77, "R5");
    ppu_read(14'h2005, "R5");

    // writes below $8000 ignored
    cpu_write(16'h7FFF, 8'h71, "R1");
    check_rom(16'h8000, "R1");
    ppu_read(14'h0000, "R1");

    // bank select, fixed upper window, next-cycle effect
    cpu_write(16'h80FF, 8'h31, "R3");
    check_rom(16'h8000, "R10");
    check_rom(16'hBFFF, "R3");
    check_rom(16'hC123, "R4");
    check_rom(16'hFFFF, "R4");

    // ignored bits 7 and 3:1
    do_reset();
    cpu_write(16'h80FF, 8'h8F, "R3");
    check_rom(16'h8456, "R3");
    ppu_read(14'h0000, "R3");

    // bus conflict: ROM byte 0x10 at $8010 under bank 0
    do_reset();
    cpu_write(16'h8010, 8'h51, "R2");
    check_rom(16'h8010, "R2");
    ppu_read(14'h0000, "R2");

    // modulo reduction on the 5-bank instance
    do_reset();
    cpu_write(16'h80FF, 8'h71, "R9");
    check_rom(16'h8001, "R9");
    chk("R9 rom5 bank", 32'(rom_addr5[16:14]), 32'd2);
    cpu_write(16'h80FF, 8'h51, "R9");
    check_rom(16'hA000, "R9");

    // mirroring strap
    mirror_strap = 1'b1;
    cpu_write(16'hFFFF, 8'hFF, "R8");
    #1 chk("R8 mirror", 32'(mirror_sel8), 32'd1);
    mirror_strap = 1'b0;
    cpu_write(16'h8000, 8'hFF, "R8");
    #1 chk("R8 mirror", 32'(mirror_sel8), 32'd0);

    // reset mid-run after enabling
    cpu_write(16'h80FF, 8'h61, "R7");
    do_reset();
    check_rom(16'h8ABC, "R7");
    ppu_read(14'h0000, "R7");

    // random traffic
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0: cpu_write(16'($urandom), 8'($urandom), "R2");
        1: check_rom(16'($urandom) | 16'h8000, "R3");
        2: ppu_write(14'($urandom_range(0, 16383)), 8'($urandom), m_en8 ? "R5" : "R6");
        default: ppu_read(14'($urandom_range(0, 16383)), m_en8 ? "R5" : "R6");
      endcase
      if (it % 50 == 0) begin
        mirror_strap = ~mirror_strap;
        #1 chk("R8 mirror", 32'(mirror_sel8), 32'(mirror_strap));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule